// File: doc/BRIEF.md
# Double-Precision to Integer Converter

This block turns a 64-bit IEEE-754 double into a 32-bit or 64-bit integer, signed or unsigned, and always rounds toward zero. It sits beside a floating-point pipeline. The caller presents the operand and an operation code with a one-cycle strobe. One clock later the block returns the integer in a 64-bit lane together with a five-bit exception vector. Out-of-range values, infinities and NaNs saturate. NaN is treated as a large positive number. Word-sized results are always sign-extended from bit 31, including the unsigned ones.

Control is a two-state machine. `ST_IDLE` is entered on reset and holds while no request arrives. The transition `GO` (in_vld high) leads to `ST_EMIT`, where the output strobe is high. From `ST_EMIT`, the transition `AGAIN` (in_vld high) stays in `ST_EMIT` for back-to-back requests, and `DRAIN` (in_vld low) returns to `ST_IDLE`. The datapath behind it has three parts: an operand classifier, a truncating aligner that forms the integer magnitude and a lost-fraction bit, and a range and saturation stage that picks the result for the selected operation.

Top module: `dbl2int_cvt`

## Requirements
- R1: The result is the operand truncated toward zero. For example, 1.1 gives 1, -1.1 gives -1, and 0.9 and -0.9 both give 0.
- R2: In the flag vector, bit 4 means invalid and bit 0 means inexact, and bits 3..1 are always 0. An operand that is already an in-range integer raises no flag. A fraction that is dropped raises inexact.
- R3: Signed word conversion (in_op = 2'b00) saturates when the value is out of range. Values of 2^31 and above give 0x000000007FFFFFFF, and values whose truncation is below -2^31 give 0xFFFFFFFF80000000, each with invalid only. -2^31 itself converts exactly.
- R4: Signed long conversion (in_op = 2'b10) saturates to 0x7FFFFFFFFFFFFFFF at 2^63 and above, and to 0x8000000000000000 below -2^63, with invalid. Values such as +/-3e9 convert exactly with no flag.
- R5: Unsigned conversion (in_op = 2'b01 or 2'b11) of a negative value whose truncation is -1 or lower returns 0 with invalid. A negative value greater than -1 returns 0 with inexact only.
- R6: Word results, signed or unsigned, are sign-extended from bit 31 to 64 bits. For example, an unsigned word conversion of 3e9 gives 0xFFFFFFFFB2D05E00. Unsigned word overflow gives all ones.
- R7: In the signed forms, a NaN of either sign and +infinity give the largest positive value (0x000000007FFFFFFF or 0x7FFFFFFFFFFFFFFF), and -infinity gives the most negative value (0xFFFFFFFF80000000 or 0x8000000000000000), each with invalid.
- R8: In the unsigned forms, a NaN of either sign and +infinity give all ones in 64 bits, and -infinity gives 0, each with invalid.
- R9: Invalid and inexact are never raised together. When invalid is raised, inexact is suppressed even if a fraction was dropped.
- R10: Zero of either sign gives 0 with no flag. A nonzero subnormal of either sign gives 0 with inexact only, in every operation.
- R11: The result and flags are registered and appear on the clock after the strobe. out_vld is high for exactly that one cycle per request, and back-to-back requests are accepted every cycle. After reset, out_vld, out_res and out_flags are 0.
- R12: in_op selects the operation: 2'b00 signed word, 2'b01 unsigned word, 2'b10 signed long, 2'b11 unsigned long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Request strobe, one cycle per operand |
| in_op | input | 2 | Operation select (see R12) |
| in_opnd | input | 64 | Double-precision operand bits |
| out_vld | output | 1 | Result strobe, one cycle after in_vld |
| out_res | output | 64 | Integer result, 64-bit lane |
| out_flags | output | 5 | Exception flags: bit 4 invalid, bit 0 inexact |

## Verification
A wrong state in the two-state controller is visible at the ports within one cycle. The strobe would be missing, doubled or stuck, which the scoreboard sees as a lost or unexpected result on the next sample. A fault in the range stage shows on the very result that crosses the faulty boundary, as a wrong saturation value or wrong flag bits. For that reason the stimulus sits on both sides of every limit: -2^31, 2^31, 2^32, 2^63, 2^64 and -1. Sign-extension faults show in the upper 32 bits of the same result, so word cases use operands whose bit 31 is set.

// File: rtl/d2i_pkg.sv
package d2i_pkg;

    parameter int FP_W     = 64;
    parameter int EXP_W    = 11;
    parameter int MAN_W    = 52;
    parameter int OUT_W    = 64;
    parameter int NARROW_W = 32;
    parameter int FLAG_W   = 5;

    localparam int FLG_INVALID = 4;
    localparam int FLG_INEXACT = 0;

    typedef enum logic [1:0] {
        OP_SW = 2'b00,
        OP_UW = 2'b01,
        OP_SL = 2'b10,
        OP_UL = 2'b11
    } cvt_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } cvt_state_e;

endpackage

// File: rtl/d2i_unpack.sv
module d2i_unpack
    import d2i_pkg::*;
(
    input  logic [FP_W-1:0]  opnd,
    output logic             sgn,
    output logic [EXP_W-1:0] expo,
    output logic [MAN_W-1:0] mant,
    output logic             is_nan,
    output logic             is_inf
);
    localparam logic [EXP_W-1:0] EXP_MAX = '1;

    always_comb begin
        sgn    = opnd[FP_W-1];
        expo   = opnd[FP_W-2 -: EXP_W];
        mant   = opnd[MAN_W-1:0];
        is_nan = (expo == EXP_MAX) && (mant != '0);
        is_inf = (expo == EXP_MAX) && (mant == '0);
    end
endmodule

// File: rtl/d2i_trunc.sv
module d2i_trunc
    import d2i_pkg::*;
(
    input  logic [EXP_W-1:0] expo,
    input  logic [MAN_W-1:0] mant,
    output logic [OUT_W-1:0] mag,
    output logic             huge,
    output logic             frac_lost
);
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam int WIDE = 2 * OUT_W;
    localparam int SHW  = $clog2(WIDE);
    localparam int PAD  = OUT_W - MAN_W;
    localparam int ZPAD = WIDE - MAN_W - 1;
    localparam logic [EXP_W-1:0] EXP_MAX = '1;

    int              unb;
    logic [SHW-1:0]  shamt;
    logic [WIDE-1:0] wide;

    always_comb begin
        unb   = int'(expo) - BIAS;
        shamt = SHW'(unb + PAD);
        wide  = {{ZPAD{1'b0}}, 1'b1, mant} << shamt;
        mag       = '0;
        huge      = 1'b0;
        frac_lost = 1'b0;
        if (expo == '0) begin
            frac_lost = (mant != '0);
        end else if (expo == EXP_MAX) begin
            huge = 1'b1;
        end else if (unb < 0) begin
            frac_lost = 1'b1;
        end else if (unb >= OUT_W) begin
            huge = 1'b1;
        end else begin
            mag       = wide[WIDE-1:OUT_W];
            frac_lost = (wide[OUT_W-1:0] != '0);
        end
    end
endmodule

// File: rtl/d2i_sat.sv
module d2i_sat
    import d2i_pkg::*;
(
    input  cvt_op_e           op,
    input  logic              sgn,
    input  logic              is_nan,
    input  logic              is_inf,
    input  logic [OUT_W-1:0]  mag,
    input  logic              huge,
    input  logic              frac_lost,
    output logic [OUT_W-1:0]  res,
    output logic [FLAG_W-1:0] flags
);
    localparam logic [OUT_W-1:0] ONE       = OUT_W'(1);
    localparam logic [OUT_W-1:0] N_POS_LIM = (ONE << (NARROW_W - 1)) - ONE;
    localparam logic [OUT_W-1:0] N_NEG_LIM = ONE << (NARROW_W - 1);
    localparam logic [OUT_W-1:0] NU_LIM    = (ONE << NARROW_W) - ONE;
    localparam logic [OUT_W-1:0] W_POS_LIM = (ONE << (OUT_W - 1)) - ONE;
    localparam logic [OUT_W-1:0] W_NEG_LIM = ONE << (OUT_W - 1);
    localparam logic [OUT_W-1:0] ALL1      = '1;

    logic [OUT_W-1:0] lim_pos, lim_neg, sat_pos, sat_neg, signed_val, pick;
    logic             narrow, ovf, invalid;

    always_comb begin
        lim_pos = ALL1;
        lim_neg = '0;
        sat_pos = ALL1;
        sat_neg = '0;
        narrow  = 1'b0;
        unique case (op)
            OP_SW: begin
                lim_pos = N_POS_LIM; lim_neg = N_NEG_LIM;
                sat_pos = N_POS_LIM; sat_neg = N_NEG_LIM;
                narrow  = 1'b1;
            end
            OP_UW: begin
                lim_pos = NU_LIM;    lim_neg = '0;
                sat_pos = NU_LIM;    sat_neg = '0;
                narrow  = 1'b1;
            end
            OP_SL: begin
                lim_pos = W_POS_LIM; lim_neg = W_NEG_LIM;
                sat_pos = W_POS_LIM; sat_neg = W_NEG_LIM;
            end
            OP_UL: begin
                lim_pos = ALL1;      lim_neg = '0;
                sat_pos = ALL1;      sat_neg = '0;
            end
            default: ;
        endcase

        ovf        = huge || (sgn ? (mag > lim_neg) : (mag > lim_pos));
        invalid    = is_nan || is_inf || ovf;
        signed_val = sgn ? (~mag + ONE) : mag;

        if (is_nan)       pick = sat_pos;
        else if (invalid) pick = sgn ? sat_neg : sat_pos;
        else              pick = signed_val;

        if (narrow) res = {{(OUT_W - NARROW_W){pick[NARROW_W-1]}}, pick[NARROW_W-1:0]};
        else        res = pick;

        flags              = '0;
        flags[FLG_INVALID] = invalid;
        flags[FLG_INEXACT] = !invalid && frac_lost;
    end
endmodule

// File: rtl/dbl2int_cvt.sv
module dbl2int_cvt
    import d2i_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [1:0]        in_op,
    input  logic [FP_W-1:0]   in_opnd,
    output logic              out_vld,
    output logic [OUT_W-1:0]  out_res,
    output logic [FLAG_W-1:0] out_flags
);
    cvt_state_e state_q, state_d;
    cvt_op_e    op_e;

    logic             sgn, is_nan, is_inf, huge, frac_lost;
    logic [EXP_W-1:0] expo;
    logic [MAN_W-1:0] mant;
    logic [OUT_W-1:0] mag, res_c;
    logic [FLAG_W-1:0] flags_c;

    assign op_e = cvt_op_e'(in_op);

    d2i_unpack u_unpack (
        .opnd   (in_opnd),
        .sgn    (sgn),
        .expo   (expo),
        .mant   (mant),
        .is_nan (is_nan),
        .is_inf (is_inf)
    );

    d2i_trunc u_trunc (
        .expo      (expo),
        .mant      (mant),
        .mag       (mag),
        .huge      (huge),
        .frac_lost (frac_lost)
    );

    d2i_sat u_sat (
        .op        (op_e),
        .sgn       (sgn),
        .is_nan    (is_nan),
        .is_inf    (is_inf),
        .mag       (mag),
        .huge      (huge),
        .frac_lost (frac_lost),
        .res       (res_c),
        .flags     (flags_c)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_vld ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_vld ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_res   <= '0;
            out_flags <= '0;
        end else if (in_vld) begin
            out_res   <= res_c;
            out_flags <= flags_c;
        end
    end

    assign out_vld = (state_q == ST_EMIT);

    AST_VLD_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld); // R11
    AST_VLD_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(in_vld)); // R11
    AST_FLAGS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> !(out_flags[FLG_INVALID] && out_flags[FLG_INEXACT])); // R9
    AST_FLAGS_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (out_flags[3:1] == '0)); // R2
    AST_WORD_SIGNEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !in_op[1]) |=>
            (out_res[OUT_W-1:NARROW_W] == {(OUT_W-NARROW_W){out_res[NARROW_W-1]}})); // R6
    AST_NAN_POS_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && is_nan && in_op == 2'b10) |=> (out_res == {1'b0, {(OUT_W-1){1'b1}}})); // R7
    AST_NAN_UNS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && is_nan && in_op[0]) |=> (out_res == '1)); // R8
endmodule

// File: tb/sim_dbl2int_cvt.sv
module sim_dbl2int_cvt;
    localparam int CLK_PERIOD = 10;

    localparam logic [1:0] SW = 2'b00, UW = 2'b01, SL = 2'b10, UL = 2'b11;
    localparam logic [63:0] NAN_N = 64'hFFFFFFFFFFFFFFFF;
    localparam logic [63:0] NAN_P = 64'h7FFFFFFFFFFFFFFF;
    localparam logic [63:0] NINF  = 64'hFFF0000000000000;
    localparam logic [63:0] PINF  = 64'h7FF0000000000000;
    localparam logic [63:0] ONES  = 64'hFFFFFFFFFFFFFFFF;
    localparam logic [63:0] WMAX  = 64'h000000007FFFFFFF;
    localparam logic [63:0] WMIN  = 64'hFFFFFFFF80000000;
    localparam logic [63:0] LMAX  = 64'h7FFFFFFFFFFFFFFF;
    localparam logic [63:0] LMIN  = 64'h8000000000000000;
    localparam logic [4:0]  F_NO = 5'h00, F_NX = 5'h01, F_NV = 5'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [1:0]  in_op = 2'b00;
    logic [63:0] in_opnd = '0;
    logic        out_vld;
    logic [63:0] out_res;
    logic [4:0]  out_flags;

    typedef struct {
        logic [63:0] r;
        logic [4:0]  f;
        string       tag;
    } exp_t;

    exp_t q[$];
    exp_t cur;
    int   total = 0;
    int   bad = 0;
    int   sent = 0;
    int   seen = 0;
    bit   finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbl2int_cvt u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_vld    (in_vld),
        .in_op     (in_op),
        .in_opnd   (in_opnd),
        .out_vld   (out_vld),
        .out_res   (out_res),
        .out_flags (out_flags)
    );

    task automatic drive(input logic [1:0] op, input logic [63:0] x,
                         input logic [63:0] er, input logic [4:0] ef, input string tag);
        exp_t e;
        @(negedge clk);
        in_vld  = 1'b1;
        in_op   = op;
        in_opnd = x;
        e.r = er; e.f = ef; e.tag = tag;
        q.push_back(e);
        sent++;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_vld = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic check1(input string tag, input logic [63:0] act, input logic [63:0] exp_v);
        total++;
        if (act !== exp_v) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp_v);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && out_vld) begin
            seen++;
            total++;
            if (q.size() == 0) begin
                bad++;
                $display("FAIL R11 unexpected out_vld act=1 exp=0");
            end else begin
                cur = q.pop_front();
                if (out_res !== cur.r || out_flags !== cur.f) begin
                    bad++;
                    $display("FAIL %s act=%h/%h exp=%h/%h", cur.tag, out_res, out_flags, cur.r, cur.f);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check1("R11 reset vld", {63'b0, out_vld}, 64'd0);
        check1("R11 reset res", out_res, 64'd0);
        check1("R11 reset flags", {59'b0, out_flags}, 64'd0);

        // R1 truncation toward zero
        drive(SW, $realtobits(-1.1), ONES, F_NX, "R1 sw -1.1");
        drive(SW, $realtobits(-1.0), ONES, F_NO, "R1 sw -1.0");
        drive(SW, $realtobits(-0.9), 64'd0, F_NX, "R1 sw -0.9");
        drive(SW, $realtobits(0.9), 64'd0, F_NX, "R1 sw 0.9");
        drive(SW, $realtobits(1.0), 64'd1, F_NO, "R2 sw 1.0 exact");
        drive(SW, $realtobits(1.1), 64'd1, F_NX, "R1 sw 1.1");
        drive(SL, $realtobits(-1.1), ONES, F_NX, "R1 sl -1.1");
        drive(UL, $realtobits(1.5), 64'd1, F_NX, "R1 ul 1.5");
        drive(SL, $realtobits(-2.75), -64'sd2, F_NX, "R1 sl -2.75");
        drive(UL, $realtobits(0.5), 64'd0, F_NX, "R2 ul 0.5");

        // R3 signed word saturation
        drive(SW, $realtobits(3e9), WMAX, F_NV, "R3 sw 3e9");
        drive(SW, $realtobits(-3e9), WMIN, F_NV, "R3 sw -3e9");
        drive(SW, $realtobits(2147483648.0), WMAX, F_NV, "R3 sw 2^31");
        drive(SW, $realtobits(2147483647.0), WMAX, F_NO, "R3 sw 2^31-1");
        drive(SW, $realtobits(-2147483648.0), WMIN, F_NO, "R3 sw -2^31");
        drive(SW, $realtobits(-2147483648.5), WMIN, F_NX, "R3 sw -2^31-0.5");
        drive(SW, $realtobits(-2147483649.0), WMIN, F_NV, "R3 sw -2^31-1");

        // R4 signed long
        drive(SL, $realtobits(3e19), LMAX, F_NV, "R4 sl 3e19");
        drive(SL, $realtobits(-3e19), LMIN, F_NV, "R4 sl -3e19");
        drive(SL, $realtobits(3e9), 64'd3000000000, F_NO, "R4 sl 3e9");
        drive(SL, $realtobits(-3e9), -64'sd3000000000, F_NO, "R4 sl -3e9");
        drive(SL, $realtobits(9223372036854775808.0), LMAX, F_NV, "R4 sl 2^63");
        drive(SL, $realtobits(-9223372036854775808.0), LMIN, F_NO, "R4 sl -2^63");

        // R5 unsigned negatives
        drive(UW, $realtobits(-3.0), 64'd0, F_NV, "R5 uw -3");
        drive(UW, $realtobits(-1.0), 64'd0, F_NV, "R5 uw -1");
        drive(UL, $realtobits(-3e9), 64'd0, F_NV, "R5 ul -3e9");
        drive(UW, $realtobits(-0.9), 64'd0, F_NX, "R5 uw -0.9");
        drive(UL, $realtobits(-0.9), 64'd0, F_NX, "R5 ul -0.9");

        // R6 sign extension and unsigned ranges
        drive(UW, $realtobits(3e9), 64'hFFFFFFFFB2D05E00, F_NO, "R6 uw 3e9");
        drive(UW, $realtobits(4294967295.0), ONES, F_NO, "R6 uw 2^32-1");
        drive(UW, $realtobits(4294967296.0), ONES, F_NV, "R6 uw 2^32");
        drive(UL, $realtobits(3e9), 64'h00000000B2D05E00, F_NO, "R6 ul 3e9");
        drive(UL, $realtobits(9223372036854775808.0), LMIN, F_NO, "R6 ul 2^63");
        drive(UL, $realtobits(18446744073709551616.0), ONES, F_NV, "R6 ul 2^64");

        // R7 signed NaN / infinity
        drive(SW, NAN_N, WMAX, F_NV, "R7 sw -nan");
        drive(SW, NAN_P, WMAX, F_NV, "R7 sw +nan");
        drive(SW, PINF, WMAX, F_NV, "R7 sw +inf");
        drive(SW, NINF, WMIN, F_NV, "R7 sw -inf");
        drive(SL, NAN_N, LMAX, F_NV, "R7 sl -nan");
        drive(SL, NAN_P, LMAX, F_NV, "R7 sl +nan");
        drive(SL, PINF, LMAX, F_NV, "R7 sl +inf");
        drive(SL, NINF, LMIN, F_NV, "R7 sl -inf");

        // R8 unsigned NaN / infinity
        drive(UW, NAN_N, ONES, F_NV, "R8 uw -nan");
        drive(UW, NAN_P, ONES, F_NV, "R8 uw +nan");
        drive(UW, NINF, 64'd0, F_NV, "R8 uw -inf");
        drive(UW, PINF, ONES, F_NV, "R8 uw +inf");
        drive(UL, NAN_N, ONES, F_NV, "R8 ul -nan");
        drive(UL, NAN_P, ONES, F_NV, "R8 ul +nan");
        drive(UL, NINF, 64'd0, F_NV, "R8 ul -inf");
        drive(UL, PINF, ONES, F_NV, "R8 ul +inf");

        // R9 invalid suppresses inexact
        drive(SW, $realtobits(3000000000.5), WMAX, F_NV, "R9 sw 3e9+0.5");
        drive(UW, $realtobits(-1.5), 64'd0, F_NV, "R9 uw -1.5");
        drive(SW, $realtobits(-2147483649.5), WMIN, F_NV, "R9 sw -2^31-1.5");

        // R10 zero and subnormal
        drive(SW, 64'h0000000000000000, 64'd0, F_NO, "R10 sw +0");
        drive(SL, 64'h8000000000000000, 64'd0, F_NO, "R10 sl -0");
        drive(UW, 64'h8000000000000000, 64'd0, F_NO, "R10 uw -0");
        drive(UL, 64'h0000000000000001, 64'd0, F_NX, "R10 ul +sub");
        drive(SW, 64'h800FFFFFFFFFFFFF, 64'd0, F_NX, "R10 sw -sub");
        drive(UW, 64'h800FFFFFFFFFFFFF, 64'd0, F_NX, "R10 uw -sub");

        // R12 same operand across all four operations
        drive(SW, $realtobits(-5.0), -64'sd5, F_NO, "R12 op 00");
        drive(UW, $realtobits(-5.0), 64'd0, F_NV, "R12 op 01");
        drive(SL, $realtobits(-5.0), -64'sd5, F_NO, "R12 op 10");
        drive(UL, $realtobits(-5.0), 64'd0, F_NV, "R12 op 11");
        idle(3);

        // R11 isolated request: strobe for exactly one cycle
        drive(SL, $realtobits(42.0), 64'd42, F_NO, "R11 isolated");
        @(negedge clk);
        in_vld = 1'b0;
        check1("R11 pulse high", {63'b0, out_vld}, 64'd1);
        @(negedge clk);
        check1("R11 pulse low", {63'b0, out_vld}, 64'd0);
        check1("R11 result held", out_res, 64'd42);
        idle(3);

        check1("R11 results matched requests", 64'(seen), 64'(sent));
        check1("R11 scoreboard drained", 64'(q.size()), 64'd0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule